// File: doc/BRIEF.md
# Dual-Lane Serial DAC Command Transmitter

This block sits on the host side of a link to two dual-channel 8-bit DAC devices. Both devices share one serial clock and one active-low frame-sync line. Each device has its own data line, which only the host drives. For each frame the block takes one 16-bit command word per lane. The caller either supplies that word whole or has the block assemble it from separate fields: load-DAC, the two power-down bits, the channel select, the two control bits and the 8-bit code. The block then shifts both words out together and raises a one-cycle completion pulse once sync has returned high and the idle gap has elapsed.

A divider value, captured at start, sets the serial rate. Each half of a serial clock period lasts divider+1 system clock cycles. Data changes on falling serial clock edges, so every bit is steady when the device samples it on the next rising edge. The devices act on a command when sync rises. The reference-select bit (bit 15) and the unused bit 14 always leave the block as 0, whatever the caller supplies, so the devices use their internal half-supply reference.

Top module: `dual_dac_tx`

## Requirements
- R1: After reset, sync_n_o and sclk_o are 1, both sdata_o lines are 0, and busy_o and done_o are 0.
- R2: Each frame has exactly 16 rising edges of sclk_o while sync_n_o is low. sclk_o stays high whenever sync_n_o is high, so no rising edge occurs outside a frame.
- R3: The bits seen on a lane at the 16 rising edges of sclk_o form that lane's command word, MSB (bit 15) first. sdata_o changes only after a falling edge of sclk_o or when a frame is loaded.
- R4: In field mode (raw_mode_i = 0), lane l sends {0, 0, cmd_ldac_i[l], cmd_pdb_i[l], cmd_pda_i[l], cmd_selb_i[l], cmd_ctl_i[2l+1], cmd_ctl_i[2l], cmd_code_i[8l+7:8l]}, from bit 15 down to bit 0.
- R5: In raw mode (raw_mode_i = 1), lane l sends raw_word_i[16l+15:16l] with bits 15 and 14 forced to 0. The field inputs have no effect.
- R6: Both lanes shift in lockstep on the shared clock and sync. Each lane carries its own word and does not affect the other.
- R7: sync_n_o rises while sclk_o is high, one half period after the 16th rising edge. It then stays high for one full serial period (two half periods) before busy_o falls.
- R8: One half period of sclk_o lasts div_i+1 system clock cycles. busy_o stays high for exactly 35*(div_i+1) cycles per frame: one half period before the first falling edge, 32 half periods of shifting and 2 half periods of gap. sync_n_o is low for the first 33*(div_i+1) of those cycles.
- R9: A start_i request while busy_o is high is ignored. Words, mode and divider are captured on the accepted start, so input changes during a frame do not alter it and no extra frame follows.
- R10: done_o pulses high for exactly one cycle, in the first cycle that busy_o is low after a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a frame; accepted only while idle |
| raw_mode_i | input | 1 | 1: send raw words, 0: build words from fields |
| raw_word_i | input | 32 | Raw command words, lane l in bits [16l+15:16l] |
| cmd_ldac_i | input | 2 | Load-DAC bit per lane |
| cmd_pdb_i | input | 2 | Power-down channel B bit per lane |
| cmd_pda_i | input | 2 | Power-down channel A bit per lane |
| cmd_selb_i | input | 2 | Channel select per lane (1 selects channel B) |
| cmd_ctl_i | input | 4 | Two control bits per lane, lane l in [2l+1:2l] |
| cmd_code_i | input | 16 | 8-bit DAC code per lane, lane l in [8l+7:8l] |
| div_i | input | 8 | Half-period length minus one, in system clocks |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| sclk_o | output | 1 | Shared serial clock, idles high |
| sync_n_o | output | 1 | Shared active-low frame sync |
| sdata_o | output | 2 | Serial data, one line per lane |

## Verification
Field-mode frames use different field values on the two lanes, so a swapped lane, a misplaced field or a reversed bit order all show up in the captured words. Raw-mode frames drive words with bits 15 and 14 set, together with garbage on the field inputs, which shows both the forcing of those bits and that the fields are ignored. Divider values of 0, 2 and 5 tell a correct half-period count from an off-by-one, through the exact busy and sync-low lengths. A frame disturbed by a start pulse and new inputs partway through shows whether capture happens at start and whether busy requests are ignored.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    localparam int WORD_W = 16;
    localparam int CODE_W = 8;
    localparam int HALVES = 2 * WORD_W;
    localparam int HALF_W = $clog2(HALVES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_GAP
    } frame_st_e;

    typedef struct packed {
        logic              ldac;
        logic              pd_b;
        logic              pd_a;
        logic              sel_b;
        logic [1:0]        ctl;
        logic [CODE_W-1:0] code;
    } dac_fields_t;

endpackage

// File: rtl/dac_word_pack.sv
module dac_word_pack
    import dac_tx_pkg::*;
(
    input  logic              raw_mode_i,
    input  logic [WORD_W-1:0] raw_word_i,
    input  dac_fields_t       fields_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] base_d;

    always_comb begin
        if (raw_mode_i) begin
            base_d = raw_word_i;
        end else begin
            base_d = {2'b00, fields_i};
        end
        word_o = base_d;
        // reference select and the unused bit always go out low
        word_o[WORD_W-1:WORD_W-2] = 2'b00;
    end

endmodule

// File: rtl/dac_rate_div.sv
module dac_rate_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             run_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } div_regs_t;

    div_regs_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        tick_o = run_i && (r_q.cnt == r_q.div);
        if (load_i) begin
            r_d.div = div_i;
        end
        if (!run_i || tick_o) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !tick_o |=> r_q.cnt == DIV_W'($past(r_q.cnt) + 1'b1));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> r_q.cnt <= r_q.div);

endmodule

// File: rtl/dac_frame_ctrl.sv
module dac_frame_ctrl
    import dac_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic load_o,
    output logic shift_o,
    output logic busy_o,
    output logic done_o,
    output logic sclk_o,
    output logic sync_n_o
);

    localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(HALVES - 1);

    typedef struct packed {
        frame_st_e         st;
        logic [HALF_W-1:0] half;
        logic              sclk;
        logic              sync_n;
        logic              done;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load_o   = 1'b0;
        shift_o  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    load_o     = 1'b1;
                    r_d.st     = ST_SETUP;
                    r_d.sync_n = 1'b0;
                    r_d.sclk   = 1'b1;
                    r_d.half   = '0;
                end
            end
            ST_SETUP: begin
                if (tick_i) begin
                    r_d.st   = ST_SHIFT;
                    r_d.sclk = 1'b0;
                    r_d.half = '0;
                end
            end
            ST_SHIFT: begin
                if (tick_i) begin
                    if (r_q.half == LAST_HALF) begin
                        r_d.st     = ST_GAP;
                        r_d.sync_n = 1'b1;
                        r_d.sclk   = 1'b1;
                        r_d.half   = '0;
                    end else begin
                        r_d.half = r_q.half + 1'b1;
                        r_d.sclk = ~r_q.sclk;
                        shift_o  = r_q.half[0];
                    end
                end
            end
            ST_GAP: begin
                if (tick_i) begin
                    if (r_q.half == HALF_W'(1)) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.half = '0;
                    end else begin
                        r_d.half = r_q.half + 1'b1;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.half   <= '0;
            r_q.sclk   <= 1'b1;
            r_q.sync_n <= 1'b1;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o   = (r_q.st != ST_IDLE);
    assign done_o   = r_q.done;
    assign sclk_o   = r_q.sclk;
    assign sync_n_o = r_q.sync_n;

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sclk_o && sync_n_o);

    // R7
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n_o) |-> sclk_o && $past(sclk_o));

    // R3
    shift_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |=> !sclk_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o));

endmodule

// File: rtl/dac_lane_shifter.sv
module dac_lane_shifter
    import dac_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sdata_o
);

    logic [WORD_W-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d = word_i;
        end else if (shift_i) begin
            sh_d = {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdata_o = sh_q[WORD_W-1];

    // R4
    first_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !sdata_o);

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && !shift_i |=> $stable(sdata_o));

endmodule

// File: rtl/dual_dac_tx.sv
module dual_dac_tx
    import dac_tx_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DIV_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     raw_mode_i,
    input  logic [LANES*WORD_W-1:0]  raw_word_i,
    input  logic [LANES-1:0]         cmd_ldac_i,
    input  logic [LANES-1:0]         cmd_pdb_i,
    input  logic [LANES-1:0]         cmd_pda_i,
    input  logic [LANES-1:0]         cmd_selb_i,
    input  logic [2*LANES-1:0]       cmd_ctl_i,
    input  logic [LANES*CODE_W-1:0]  cmd_code_i,
    input  logic [DIV_W-1:0]         div_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     sclk_o,
    output logic                     sync_n_o,
    output logic [LANES-1:0]         sdata_o
);

    logic load, shift, tick;

    dac_frame_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .tick_i   (tick),
        .load_o   (load),
        .shift_o  (shift),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .sclk_o   (sclk_o),
        .sync_n_o (sync_n_o)
    );

    dac_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .div_i  (div_i),
        .run_i  (busy_o),
        .tick_o (tick)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dac_fields_t       fields;
        logic [WORD_W-1:0] word;

        assign fields.ldac  = cmd_ldac_i[l];
        assign fields.pd_b  = cmd_pdb_i[l];
        assign fields.pd_a  = cmd_pda_i[l];
        assign fields.sel_b = cmd_selb_i[l];
        assign fields.ctl   = cmd_ctl_i[2*l +: 2];
        assign fields.code  = cmd_code_i[CODE_W*l +: CODE_W];

        dac_word_pack u_pack (
            .raw_mode_i (raw_mode_i),
            .raw_word_i (raw_word_i[WORD_W*l +: WORD_W]),
            .fields_i   (fields),
            .word_o     (word)
        );

        dac_lane_shifter u_shift (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .shift_i (shift),
            .word_i  (word),
            .sdata_o (sdata_o[l])
        );
    end

    // R6
    lanes_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !sync_n_o && sclk_o);

endmodule

// File: tb/dual_dac_tx_tb.sv
module dual_dac_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        raw_mode = 1'b0;
    logic [31:0] raw_word = '0;
    logic [1:0]  ldac = '0, pdb = '0, pda = '0, selb = '0;
    logic [3:0]  ctl = '0;
    logic [15:0] code = '0;
    logic [7:0]  div = '0;
    logic        busy, done, sclk, sync_n;
    logic [1:0]  sdata;

    int checks = 0;
    int errors = 0;
    longint cycles = 0;

    always #2.5 clk = ~clk;

    dual_dac_tx dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .raw_mode_i(raw_mode),
        .raw_word_i(raw_word), .cmd_ldac_i(ldac), .cmd_pdb_i(pdb),
        .cmd_pda_i(pda), .cmd_selb_i(selb), .cmd_ctl_i(ctl),
        .cmd_code_i(code), .div_i(div), .busy_o(busy), .done_o(done),
        .sclk_o(sclk), .sync_n_o(sync_n), .sdata_o(sdata)
    );

    // serial monitor, as a receiving device would see the lines
    logic [15:0] cap0 = '0, cap1 = '0, fr0 = '0, fr1 = '0;
    int edges = 0, fr_edges = 0, stray = 0;
    logic sclk_at_sync_rise = 1'b0;

    always @(negedge sync_n) begin
        edges = 0;
    end
    always @(posedge sclk) begin
        if (rst_n && sync_n === 1'b0) begin
            edges++;
            cap0 = {cap0[14:0], sdata[0]};
            cap1 = {cap1[14:0], sdata[1]};
        end else if (rst_n && sync_n === 1'b1) begin
            stray++;
        end
    end
    always @(posedge sync_n) begin
        if (rst_n) begin
            fr_edges = edges;
            fr0 = cap0;
            fr1 = cap1;
            sclk_at_sync_rise = sclk;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fexp(input int l);
        return {2'b00, ldac[l], pdb[l], pda[l], selb[l], ctl[2*l +: 2], code[8*l +: 8]};
    endfunction

    // one frame with full checks; disturb injects a busy start and new inputs
    task automatic do_frame(input logic rm, input logic [31:0] rw, input logic [7:0] dv,
                            input logic [15:0] e0, input logic [15:0] e1, input bit disturb);
        int n_busy = 0;
        int n_low = 0;
        int h = int'(dv) + 1;
        @(negedge clk);
        raw_mode = rm; raw_word = rw; div = dv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy && n_busy < 5000) begin
            n_busy++;
            if (!sync_n) n_low++;
            if (disturb && n_busy == 7) begin
                start = 1'b1; raw_word = ~rw; raw_mode = ~rm; div = 8'd0;
                ldac = ~ldac; code = ~code;
            end
            if (disturb && n_busy == 8) start = 1'b0;
            @(negedge clk);
        end
        check(n_busy == 35*h, "R8 busy length", n_busy, 35*h);
        check(n_low == 33*h, "R7 sync low length / gap", n_low, 33*h);
        check(done == 1'b1, "R10 done at busy fall", done, 1);
        check(fr_edges == 16, "R2 rising edges per frame", fr_edges, 16);
        check(sclk_at_sync_rise == 1'b1, "R7 sclk high at sync rise", sclk_at_sync_rise, 1);
        check(fr0 == e0, "R3 lane 0 word", fr0, e0);
        check(fr1 == e1, "R6 lane 1 word", fr1, e1);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R9 no extra frame", busy, 0);
    endtask

    task automatic t_reset();
        check(sync_n == 1'b1, "R1 sync idle", sync_n, 1);
        check(sclk == 1'b1, "R1 sclk idle", sclk, 1);
        check(sdata == 2'b00, "R1 data idle", sdata, 0);
        check(busy == 1'b0, "R1 busy idle", busy, 0);
        check(done == 1'b0, "R1 done idle", done, 0);
    endtask

    task automatic t_fields();
        // R4: lane 0 and lane 1 use different field values
        ldac = 2'b01; pdb = 2'b10; pda = 2'b01; selb = 2'b10;
        ctl = 4'b0110; code = 16'h3CA5;
        do_frame(1'b0, 32'hFFFF_FFFF, 8'd0, fexp(0), fexp(1), 1'b0);
        ldac = 2'b10; pdb = 2'b01; pda = 2'b10; selb = 2'b01;
        ctl = 4'b1001; code = 16'h81FE;
        do_frame(1'b0, 32'h0, 8'd2, fexp(0), fexp(1), 1'b0);
    endtask

    task automatic t_raw();
        // R5: bits 15/14 set in raw words; fields hold garbage
        ldac = 2'b11; pdb = 2'b11; pda = 2'b11; selb = 2'b11; ctl = 4'hF; code = 16'hFFFF;
        do_frame(1'b1, 32'h0000_FFFF, 8'd5, 16'h3FFF, 16'h0000, 1'b0);
        do_frame(1'b1, 32'hC000_9A5C, 8'd1, 16'h1A5C, 16'h0000, 1'b0);
    endtask

    task automatic t_busy_ignore();
        // R9: start and new inputs during a frame have no effect
        ldac = 2'b01; pdb = 2'b00; pda = 2'b10; selb = 2'b01; ctl = 4'b1100; code = 16'h7E18;
        do_frame(1'b0, 32'hAAAA_5555, 8'd2, fexp(0), fexp(1), 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_raw();
        t_busy_ignore();
        check(stray == 0, "R2 no sclk rise outside frame", stray, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule